// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block models the memory side of a double-data-rate read. Commands arrive on a two-bit command port together with a column address and a burst-length code. The block is clocked at twice the memory clock rate. It derives the memory clock phase itself and brings it out on `ck_out`. Commands are sampled only on the fast-clock edge that begins a memory cycle.

Each memory cycle after a read can release one pair of data transfers. The pair is fetched as a double-width word from a computed array model. It then travels through a CAS-latency pipeline and appears on the data output as two half-cycle transfers. The first transfer goes out in the first half of the memory cycle and the second in the second half. A strobe is driven with them, edge-aligned: it is high with the first transfer and low with the second.

The strobe is framed by a low preamble and a low postamble. Both are left out when bursts follow each other with no idle cycle between them. Interrupting commands cut a burst short, one pair per command slot. The output enables model a released bus whenever nothing is being driven.

Top module: `ddr_read_burst_seq`

## Requirements
- R1: Command codes are `00` no-op, `01` READ, and `10` or `11` interrupt. A command is acted on only at the fast edge that starts a memory cycle. That edge is the one at which `ck_out` goes from 0 to 1. A command present at the other fast edge has no effect.
- R2: The burst-length code selects the number of transfers: 0 gives 2, 1 gives 4, 2 gives 8, and 3 also gives 8.
- R3: The first pair of a READ accepted at memory cycle T is driven in memory cycle T+CAS_LAT, where CAS_LAT defaults to 2.
- R4: During a pair, the first transfer is driven while `ck_out` is 1 and the second while `ck_out` is 0. The strobe equals `ck_out`, and both output enables are 1.
- R5: Transfer t of a burst with start column s and length L reads column (s rounded down to a multiple of L) + ((s + t) mod L). The value at column c is ((c*37 + 11) mod 2^W) xor ((c div 8) mod 2^W), where W is the data width.
- R6: An interrupt in the j-th memory cycle after a READ, for 1 <= j < L/2, leaves exactly j pairs driven. An interrupt while no burst is active has no effect.
- R7: The first pair of a READ is always driven, even when an interrupt follows in the very next slot.
- R8: A READ accepted while a burst is active ends that burst and starts the new one. The pairs follow with no gap, and the strobe keeps toggling with no preamble or postamble between them.
- R9: Before a pair that follows an idle memory cycle, the strobe is enabled and held low for that whole idle cycle (the preamble).
- R10: After the last pair of a run, the strobe is enabled and held low for the first half of the next memory cycle (the postamble). It is then released unless a preamble follows.
- R11: When no pair is driven, the data enable is 0 and the data output is 0. The strobe is 0, and its enable is 1 only during a preamble or postamble.
- R12: While reset is held, all outputs and `ck_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command code |
| col_addr | input | COL_W | Start column of a READ |
| bl_code | input | 2 | Burst-length code of a READ |
| ck_out | output | 1 | Memory clock phase, 1 in the first half of a memory cycle |
| dq | output | DQ_W | Data transfer |
| dq_oe | output | 1 | Data output enable |
| dqs | output | 1 | Data strobe |
| dqs_oe | output | 1 | Strobe output enable |

## Verification
The bench goes after interrupts in the first, second and third slot after a READ. A design that counts slots from the wrong edge drives one pair too many or too few there, and so does one that lets an interrupt cancel the first pair. Chains of reads with no gap catch a design that inserts a postamble or preamble between sources, or that drops the strobe for one cycle. A single idle cycle between two bursts catches a design that mishandles overlapping postamble and preamble. A start column near the top of the address space catches a wrap that leaks outside the aligned block. A command placed at the off-phase fast edge shows whether the design samples on both edges, which would produce a spurious burst.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  localparam logic [1:0] CMD_NOP  = 2'b00;
  localparam logic [1:0] CMD_READ = 2'b01;

  // Upper command bit marks any interrupting command.
  function automatic logic is_interrupt(input logic [1:0] c);
    return c[1];
  endfunction

  // Transfers per burst for a length code; the spare code means eight.
  function automatic int unsigned burst_len(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 4;
      default: return 8;
    endcase
  endfunction

  // Column of transfer t, wrapping inside the length-aligned block.
  function automatic int unsigned wrap_col(input int unsigned start,
                                           input int unsigned blen,
                                           input int unsigned t);
    int unsigned msk;
    msk = blen - 1;
    return (start & ~msk) | ((start + t) & msk);
  endfunction

  // Content of the array model at one column, before width truncation.
  function automatic logic [31:0] cell_word(input int unsigned c);
    return (c * 37 + 11) ^ (c >> 3);
  endfunction

endpackage

// File: rtl/ddr_rd_phase.sv
module ddr_rd_phase (
  input  logic clk,
  input  logic rst,
  output logic ph,
  output logic mem_edge
);
  // ph is 1 in the first half of a memory cycle, 0 in the second.
  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  // The fast edge that follows a second half starts a memory cycle.
  assign mem_edge = ~ph;

  // R12: the phase alternates on every fast edge once reset is gone.
  a_r12_phase_alternates: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ph != $past(ph)));

endmodule

// File: rtl/ddr_rd_array.sv
module ddr_rd_array #(
  parameter int COL_W = 10,
  parameter int DQ_W  = 8,
  parameter int PORTS = 2
) (
  input  logic [COL_W-1:0] rd_col  [PORTS],
  output logic [DQ_W-1:0]  rd_data [PORTS]
);
  import ddr_rd_pkg::*;

  // One computed read lane per half of the prefetch word.
  for (genvar p = 0; p < PORTS; p++) begin : g_lane
    assign rd_data[p] = DQ_W'(cell_word(32'(rd_col[p])));
  end

endmodule

// File: rtl/ddr_rd_slot_seq.sv
module ddr_rd_slot_seq #(
  parameter int COL_W = 10,
  parameter int DQ_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mem_edge,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] col_addr,
  input  logic [1:0]       bl_code,
  output logic             iss_v,
  output logic [DQ_W-1:0]  iss_lo,
  output logic [DQ_W-1:0]  iss_hi
);
  import ddr_rd_pkg::*;

  localparam int IDX_W = 2;   // up to four pairs per burst

  logic [COL_W-1:0] start_q, sel_start;
  logic [3:0]       blen_q, sel_blen;
  logic [IDX_W-1:0] nxt_q, sel_idx;
  logic             act_q;
  logic             is_rd, is_int;

  logic [COL_W-1:0] pf_col  [2];
  logic [DQ_W-1:0]  pf_data [2];

  assign is_rd  = (cmd == CMD_READ);
  assign is_int = is_interrupt(cmd);

  // Choose which burst the current slot serves and whether it releases a pair.
  always_comb begin
    sel_start = start_q;
    sel_blen  = blen_q;
    sel_idx   = nxt_q;
    iss_v     = 1'b0;
    if (mem_edge) begin
      if (is_rd) begin
        sel_start = col_addr;
        sel_blen  = 4'(burst_len(bl_code));
        sel_idx   = '0;
        iss_v     = 1'b1;
      end else if (!is_int && act_q) begin
        iss_v     = 1'b1;
      end
    end
  end

  // Prefetch: both columns of the selected pair in one access.
  assign pf_col[0] = COL_W'(wrap_col(32'(sel_start), 32'(sel_blen), 32'(sel_idx) * 2));
  assign pf_col[1] = COL_W'(wrap_col(32'(sel_start), 32'(sel_blen), 32'(sel_idx) * 2 + 1));

  ddr_rd_array #(.COL_W(COL_W), .DQ_W(DQ_W), .PORTS(2)) u_array (
    .rd_col  (pf_col),
    .rd_data (pf_data)
  );

  assign iss_lo = pf_data[0];
  assign iss_hi = pf_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      blen_q  <= 4'd2;
      nxt_q   <= '0;
      act_q   <= 1'b0;
    end else if (mem_edge) begin
      if (is_rd) begin
        start_q <= col_addr;
        blen_q  <= 4'(burst_len(bl_code));
        nxt_q   <= IDX_W'(1);
        act_q   <= (burst_len(bl_code) > 2);
      end else if (is_int) begin
        act_q   <= 1'b0;
      end else if (act_q) begin
        nxt_q   <= nxt_q + IDX_W'(1);
        act_q   <= ((32'(nxt_q) + 1) * 2 < 32'(blen_q));
      end
    end
  end

  // R1: nothing in the burst state moves at the off-phase fast edge.
  a_r1_hold_off_edge: assert property (@(posedge clk) disable iff (rst)
    !mem_edge |=> ($stable(act_q) && $stable(nxt_q) && $stable(start_q)));

  // R6: an interrupt in a slot leaves no burst running.
  a_r6_interrupt_stops: assert property (@(posedge clk) disable iff (rst)
    (mem_edge && is_int) |=> !act_q);

  // R2: a running burst never points past its own length.
  a_r2_index_in_burst: assert property (@(posedge clk) disable iff (rst)
    act_q |-> ((32'(nxt_q) * 2) < 32'(blen_q)));

endmodule

// File: rtl/ddr_rd_lat_pipe.sv
module ddr_rd_lat_pipe #(
  parameter int DQ_W = 8,
  parameter int CL   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mem_edge,
  input  logic            iss_v,
  input  logic [DQ_W-1:0] iss_lo,
  input  logic [DQ_W-1:0] iss_hi,
  output logic            cur_v,
  output logic [DQ_W-1:0] cur_lo,
  output logic [DQ_W-1:0] cur_hi,
  output logic            prv_v,
  output logic            up_v
);
  logic [CL-1:0]   stg_v;
  logic [DQ_W-1:0] stg_lo [CL];
  logic [DQ_W-1:0] stg_hi [CL];

  // One stage per memory cycle of CAS latency, shifted at each memory edge.
  for (genvar k = 0; k < CL; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           stg_v[k] <= 1'b0;
        else if (mem_edge) stg_v[k] <= iss_v;
      end
      always_ff @(posedge clk) begin
        if (mem_edge) begin
          stg_lo[k] <= iss_lo;
          stg_hi[k] <= iss_hi;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)           stg_v[k] <= 1'b0;
        else if (mem_edge) stg_v[k] <= stg_v[k-1];
      end
      always_ff @(posedge clk) begin
        if (mem_edge) begin
          stg_lo[k] <= stg_lo[k-1];
          stg_hi[k] <= stg_hi[k-1];
        end
      end
    end
  end

  // The last stage holds the pair for the coming memory cycle.
  assign up_v = stg_v[CL-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v <= 1'b0;
      prv_v <= 1'b0;
    end else if (mem_edge) begin
      cur_v <= stg_v[CL-1];
      prv_v <= cur_v;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_edge) begin
      cur_lo <= stg_lo[CL-1];
      cur_hi <= stg_hi[CL-1];
    end
  end

  // R8: a pair announced for the next cycle is the one that gets driven.
  a_r8_announced_pair_driven: assert property (@(posedge clk) disable iff (rst)
    (mem_edge && up_v) |=> cur_v);

endmodule

// File: rtl/ddr_rd_pad_drive.sv
module ddr_rd_pad_drive #(
  parameter int DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ph,
  input  logic            cur_v,
  input  logic [DQ_W-1:0] cur_lo,
  input  logic [DQ_W-1:0] cur_hi,
  input  logic            prv_v,
  input  logic            up_v,
  output logic [DQ_W-1:0] dq,
  output logic            dq_oe,
  output logic            dqs,
  output logic            dqs_oe
);
  // Output phase: ph selects the transfer half; idle cycles frame the strobe.
  always_comb begin
    dq     = '0;
    dq_oe  = 1'b0;
    dqs    = 1'b0;
    dqs_oe = 1'b0;
    if (cur_v) begin
      dq_oe  = 1'b1;
      dqs_oe = 1'b1;
      dq     = ph ? cur_lo : cur_hi;
      dqs    = ph;
    end else if ((prv_v && ph) || up_v) begin
      dqs_oe = 1'b1;
    end
  end

  // R9: the data burst begins only after a driven-low strobe.
  a_r9_preamble_before_data: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> ($past(dqs_oe) && !$past(dqs)));

  // R10: when data stops, the strobe stays driven low.
  a_r10_postamble_after_data: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_oe) |-> (dqs_oe && !dqs));

endmodule

// File: rtl/ddr_read_burst_seq.sv
module ddr_read_burst_seq #(
  parameter int DQ_W    = 8,
  parameter int COL_W   = 10,
  parameter int CAS_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] col_addr,
  input  logic [1:0]       bl_code,
  output logic             ck_out,
  output logic [DQ_W-1:0]  dq,
  output logic             dq_oe,
  output logic             dqs,
  output logic             dqs_oe
);
  logic            ph, mem_edge;
  logic            iss_v;
  logic [DQ_W-1:0] iss_lo, iss_hi;
  logic            cur_v, prv_v, up_v;
  logic [DQ_W-1:0] cur_lo, cur_hi;

  ddr_rd_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .ph       (ph),
    .mem_edge (mem_edge)
  );

  ddr_rd_slot_seq #(.COL_W(COL_W), .DQ_W(DQ_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .mem_edge (mem_edge),
    .cmd      (cmd),
    .col_addr (col_addr),
    .bl_code  (bl_code),
    .iss_v    (iss_v),
    .iss_lo   (iss_lo),
    .iss_hi   (iss_hi)
  );

  ddr_rd_lat_pipe #(.DQ_W(DQ_W), .CL(CAS_LAT)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .mem_edge (mem_edge),
    .iss_v    (iss_v),
    .iss_lo   (iss_lo),
    .iss_hi   (iss_hi),
    .cur_v    (cur_v),
    .cur_lo   (cur_lo),
    .cur_hi   (cur_hi),
    .prv_v    (prv_v),
    .up_v     (up_v)
  );

  ddr_rd_pad_drive #(.DQ_W(DQ_W)) u_pad (
    .clk      (clk),
    .rst      (rst),
    .ph       (ph),
    .cur_v    (cur_v),
    .cur_lo   (cur_lo),
    .cur_hi   (cur_hi),
    .prv_v    (prv_v),
    .up_v     (up_v),
    .dq       (dq),
    .dq_oe    (dq_oe),
    .dqs      (dqs),
    .dqs_oe   (dqs_oe)
  );

  assign ck_out = ph;

  // R4: while data is driven the strobe follows the memory clock phase.
  a_r4_strobe_edge_aligned: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (dqs == ck_out));

  // R11: a released strobe means a quiet, released data bus.
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !dqs_oe |-> (!dq_oe && dq == '0 && !dqs));

endmodule

// File: tb/tb_ddr_read_burst_seq.sv
`timescale 1ns/1ps
module tb_ddr_read_burst_seq;
  localparam int DQ_W = 8;
  localparam int COL_W = 10;
  localparam int CL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic [COL_W-1:0] col_addr = '0;
  logic [1:0] bl_code = 2'b00;
  logic ck_out, dq_oe, dqs, dqs_oe;
  logic [DQ_W-1:0] dq;

  always #4 clk = ~clk;   // 125 MHz

  ddr_read_burst_seq #(.DQ_W(DQ_W), .COL_W(COL_W), .CAS_LAT(CL)) dut (
    .clk(clk), .rst(rst), .cmd(cmd), .col_addr(col_addr), .bl_code(bl_code),
    .ck_out(ck_out), .dq(dq), .dq_oe(dq_oe), .dqs(dqs), .dqs_oe(dqs_oe)
  );

  typedef struct { int cyc; int lo; int hi; } item_t;
  item_t exp_q[$];
  bit    busy[int];

  int checks = 0, failures = 0;
  int cyc = 0;
  int obs_pairs = 0;
  int last_hi = 0;
  bit done = 0;

  // bench reference state
  int m_start = 0, m_len = 2, m_idx = 0;
  bit m_act = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] code);
    return (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
  endfunction

  function automatic int cell_of(input int c);
    return ((c * 37 + 11) % 256) ^ ((c / 8) % 256);
  endfunction

  function automatic int col_of(input int s, input int len, input int t);
    return (s - (s % len)) + ((s + t) % len);
  endfunction

  task automatic push_pair(input int out_cyc);
    item_t it;
    it.cyc = out_cyc;
    it.lo  = cell_of(col_of(m_start, m_len, 2 * m_idx));
    it.hi  = cell_of(col_of(m_start, m_len, 2 * m_idx + 1));
    exp_q.push_back(it);
    busy[out_cyc] = 1'b1;
  endtask

  // Driver: one command per memory slot, expected pairs into the queue.
  task automatic slot(input logic [1:0] c, input int colv, input logic [1:0] blc);
    int s;
    @(negedge clk);
    while (ck_out !== 1'b0) @(negedge clk);
    s = cyc + 1;
    cmd = c; col_addr = COL_W'(colv); bl_code = blc;
    if (c == 2'b01) begin
      m_start = colv; m_len = len_of(blc); m_idx = 0; m_act = 1'b1;
    end else if (c[1]) begin
      m_act = 1'b0;
    end
    if (m_act) begin
      push_pair(s + CL);
      m_idx++;
      if (m_idx * 2 >= m_len) m_act = 1'b0;
    end
    @(negedge clk);
    cmd = 2'b00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(2'b00, 0, 2'b00);
  endtask

  // Command placed only at the off-phase fast edge.
  task automatic stray(input int colv);
    @(negedge clk);
    while (ck_out !== 1'b1) @(negedge clk);
    cmd = 2'b01; col_addr = COL_W'(colv); bl_code = 2'd2;
    @(negedge clk);
    cmd = 2'b00;
  endtask

  task automatic expect_pairs(input int base, input int n, input string tag);
    idle(CL + 3);
    chk(obs_pairs - base == n, tag, obs_pairs - base, n);
  endtask

  // Monitor: pops expected pairs and checks every half cycle.
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0;
    end else if (ck_out === 1'b1) begin
      cyc = cyc + 1;
      if (busy.exists(cyc)) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 queue empty", 0, 1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          last_hi = it.hi;
          chk(it.cyc == cyc, "R3 pair order", cyc, it.cyc);
          chk(dq_oe === 1'b1 && dqs_oe === 1'b1, "R3 enables", int'(dq_oe), 1);
          chk(dqs === 1'b1, busy.exists(cyc - 1) ? "R8 strobe high" : "R4 strobe high", int'(dqs), 1);
          chk(dq === DQ_W'(it.lo), "R5 first transfer", int'(dq), it.lo);
          if (dq_oe === 1'b1) obs_pairs++;
        end
      end else begin
        chk(dq_oe === 1'b0 && dq === '0 && dqs === 1'b0, "R11 idle first half", int'(dq), 0);
        chk(dqs_oe === (busy.exists(cyc - 1) || busy.exists(cyc + 1)),
            busy.exists(cyc - 1) ? "R10 postamble" : (busy.exists(cyc + 1) ? "R9 preamble" : "R11 released"),
            int'(dqs_oe), int'(busy.exists(cyc - 1) || busy.exists(cyc + 1)));
      end
    end else if (ck_out === 1'b0 && cyc > 0) begin
      if (busy.exists(cyc)) begin
        chk(dq === DQ_W'(last_hi), "R5 second transfer", int'(dq), last_hi);
        chk(dqs === 1'b0 && dqs_oe === 1'b1 && dq_oe === 1'b1, "R4 strobe low", int'(dqs), 0);
      end else begin
        chk(dq_oe === 1'b0 && dqs === 1'b0, "R11 idle second half", int'(dq_oe), 0);
        chk(dqs_oe === busy.exists(cyc + 1),
            busy.exists(cyc + 1) ? "R9 preamble" : "R10 release",
            int'(dqs_oe), int'(busy.exists(cyc + 1)));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(ck_out === 1'b0 && dq_oe === 1'b0 && dqs_oe === 1'b0, "R12 reset enables", int'(dq_oe), 0);
    chk(dq === '0 && dqs === 1'b0, "R12 reset values", int'(dq), 0);
    rst = 1'b0;
    idle(3);

    // R3 R5: full burst of eight from column 0
    b = obs_pairs;
    slot(2'b01, 0, 2'd2); idle(3);
    expect_pairs(b, 4, "R3 full burst of eight");

    // R5: wrap inside a four-transfer block
    b = obs_pairs;
    slot(2'b01, 13, 2'd1);
    expect_pairs(b, 2, "R5 wrapped burst of four");

    // R2: code 0 gives one pair
    b = obs_pairs;
    slot(2'b01, 6, 2'd0);
    expect_pairs(b, 1, "R2 burst of two");

    // R7: interrupt in the first slot keeps the first pair
    b = obs_pairs;
    slot(2'b01, 5, 2'd2); slot(2'b10, 0, 2'd0);
    expect_pairs(b, 1, "R7 first pair kept");

    // R6: interrupt in the second and third slots
    b = obs_pairs;
    slot(2'b01, 3, 2'd2); slot(2'b00, 0, 2'd0); slot(2'b10, 0, 2'd0);
    expect_pairs(b, 2, "R6 interrupt second slot");
    b = obs_pairs;
    slot(2'b01, 3, 2'd2); idle(2); slot(2'b11, 0, 2'd0);
    expect_pairs(b, 3, "R6 interrupt third slot code 11");

    // R8: back-to-back reads, one truncating another
    b = obs_pairs;
    slot(2'b01, 20, 2'd0); slot(2'b01, 40, 2'd0); slot(2'b01, 61, 2'd1);
    slot(2'b01, 100, 2'd2); idle(3);
    expect_pairs(b, 7, "R8 back-to-back chain");

    // R2: spare code means eight, with wrap at the top of the column space
    b = obs_pairs;
    slot(2'b01, 1021, 2'd3); idle(3);
    expect_pairs(b, 4, "R2 spare code is eight");

    // R6: interrupt while idle has no effect
    b = obs_pairs;
    slot(2'b10, 0, 2'd0);
    expect_pairs(b, 0, "R6 idle interrupt ignored");

    // R1: command at the off-phase edge is ignored
    b = obs_pairs;
    stray(77);
    expect_pairs(b, 0, "R1 off-phase command ignored");

    // R9 R10: single idle cycle between two bursts
    b = obs_pairs;
    slot(2'b01, 9, 2'd0); slot(2'b00, 0, 2'd0); slot(2'b01, 11, 2'd0);
    expect_pairs(b, 2, "R10 postamble meets preamble");

    idle(4);
    chk(exp_q.size() == 0, "R3 all pairs seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule